// File: doc/BRIEF.md
# Cassette Controller Register Interface

This block is the processor-facing register file of a two-drive cassette tape controller. Software sees two word locations, picked by address bit 1: a 16-bit control/status word and a data buffer whose low byte carries one tape character. The block takes both word and byte writes. It merges the byte lanes, keeps only the software-writable fields, and sends a one-cycle start pulse, together with the chosen drive and function, to a separate operation sequencer.

The sequencer has no direct access to the status word. It reports back through event inputs: request a transfer, load an input byte, finish an operation, and raise individual status conditions. The block owns the transfer-request, ready, error and status flags. It detects a transfer request that arrives while the previous one is still pending, and it drives one level-sensitive interrupt request.

Top module: `cas_regif_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, the status word reads 0x0020 (only ready set, with drive 0 loaded). Both data bytes read 0 and irq is 0.
- R2: The status word bit positions are: 15 error, 14 CRC, 13 BOT/EOT, 12 write lock, 11 end-of-file, 10 timing, 9 empty, 8 unit, 7 transfer request, 6 interrupt enable, 5 ready, 4 start-CRC, 3:1 function, 0 go. A status write changes only bits 8, 6, 4 and 3:1 (mask 0x015E).
- R3: A byte write (bus_byte=1) takes its data from bus_wdata[7:0]. When bus_addr[0]=1 that byte replaces bits 15:8 and bits 7:0 are kept. When bus_addr[0]=0 it replaces bits 7:0 and bits 15:8 are kept. The writable mask is applied after the merge.
- R4: A status write whose merged bit 0 is 1, made while seq_busy=0, gives start_pulse=1 for exactly the next cycle. start_unit and start_func carry the written bit 8 and bits 3:1. Bit 0 always reads 0.
- R5: A go written while seq_busy=1 produces no start pulse and leaves the hardware flags unchanged.
- R6: An accepted go clears error, CRC, BOT/EOT, write lock, end-of-file, timing, empty, transfer request and ready (mask 0xFEA0) before any empty/ready forcing.
- R7: Reading the data location (bus_addr[1]=1) returns {8'h00, input byte} and clears transfer request. A word write, or an even byte write, to it loads out_byte from bus_wdata[7:0] and clears transfer request. An odd byte write (bus_addr=3, bus_byte=1) changes nothing.
- R8: seq_tr_req sets transfer request when it is 0. When it is already 1, it sets error and timing instead.
- R9: After any status write that leaves start-CRC (bit 4) set, transfer request is 0.
- R10: irq is 1 exactly when interrupt enable is 1 and either transfer request or ready is 1.
- R11: While drv_loaded[unit] is 0, the next state has empty and ready set. Otherwise empty is 0.
- R12: seq_stat_set bits 0..4 set error, CRC, BOT/EOT, write lock and end-of-file. seq_done sets ready. seq_in_load loads the input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Bit 1 selects the location, bit 0 selects the byte lane |
| bus_byte | input | 1 | 1 for a byte access |
| bus_wdata | input | 16 | Write data (byte data in bits 7:0) |
| bus_rdata | output | 16 | Read data for the addressed location |
| seq_busy | input | 1 | A drive operation is in progress |
| seq_tr_req | input | 1 | Sequencer asks for a transfer request |
| seq_done | input | 1 | Operation finished, set ready |
| seq_stat_set | input | 5 | Set error, CRC, BOT/EOT, write lock, end-of-file |
| seq_in_load | input | 1 | Load seq_in_byte into the input buffer |
| seq_in_byte | input | 8 | Character read from tape |
| drv_loaded | input | 2 | Cassette present, one bit per drive |
| start_pulse | output | 1 | One-cycle operation start |
| start_unit | output | 1 | Drive captured at start |
| start_func | output | 3 | Function captured at start |
| out_byte | output | 8 | Character for the sequencer to write |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a transfer request that is still pending when the next one arrives. Software normally clears the flag by reading or writing the data location, so the stimulus has to raise two sequencer requests with no data access between them. The timing error must then survive later accesses until a new go clears it. A second awkward case combines a missing cassette with a status write that selects that drive. The stimulus also removes the cassette while the drive is selected, so that the forced empty and ready must appear in the following cycle and drop once the unit field points to a loaded drive.

// File: rtl/cas_regif_pkg.sv
`timescale 1ns/1ps
package cas_regif_pkg;
  localparam int NUM_DRIVES = 2;
  localparam int UNIT_W     = $clog2(NUM_DRIVES);
  localparam int CSR_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int FUNC_W     = 3;
  localparam int STAT_N     = 5;

  localparam int B_ERR  = 15;
  localparam int B_CRC  = 14;
  localparam int B_BEOT = 13;
  localparam int B_WLK  = 12;
  localparam int B_EOF  = 11;
  localparam int B_TIM  = 10;
  localparam int B_EMP  = 9;
  localparam int B_UNIT = 8;
  localparam int B_TR   = 7;
  localparam int B_IE   = 6;
  localparam int B_RDY  = 5;
  localparam int B_ILBS = 4;
  localparam int B_FUNC = 1;
  localparam int B_GO   = 0;

  function automatic logic [CSR_W-1:0] bit_at(input int pos);
    logic [CSR_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [CSR_W-1:0] sw_mask();
    logic [CSR_W-1:0] m;
    m = bit_at(B_UNIT) | bit_at(B_IE) | bit_at(B_ILBS);
    for (int i = 0; i < FUNC_W; i++) m |= bit_at(B_FUNC + i);
    return m;
  endfunction

  function automatic logic [CSR_W-1:0] start_clr_mask();
    return bit_at(B_ERR) | bit_at(B_CRC) | bit_at(B_BEOT) | bit_at(B_WLK) |
           bit_at(B_EOF) | bit_at(B_TIM) | bit_at(B_EMP) | bit_at(B_TR) |
           bit_at(B_RDY);
  endfunction

  // byte lane merge: byte data always arrives on the low lane
  function automatic logic [CSR_W-1:0] merge_lanes(input logic [CSR_W-1:0] cur,
                                                   input logic [CSR_W-1:0] wd,
                                                   input logic is_byte,
                                                   input logic odd);
    if (!is_byte) return wd;
    if (odd) return {wd[BYTE_W-1:0], cur[BYTE_W-1:0]};
    return {cur[CSR_W-1:BYTE_W], wd[BYTE_W-1:0]};
  endfunction

  function automatic logic [CSR_W-1:0] apply_sw(input logic [CSR_W-1:0] cur,
                                                input logic [CSR_W-1:0] merged);
    return (cur & ~sw_mask()) | (merged & sw_mask());
  endfunction

  function automatic logic [CSR_W-1:0] stat_bits(input logic [STAT_N-1:0] s);
    logic [CSR_W-1:0] v;
    v = '0;
    if (s[0]) v |= bit_at(B_ERR);
    if (s[1]) v |= bit_at(B_CRC);
    if (s[2]) v |= bit_at(B_BEOT);
    if (s[3]) v |= bit_at(B_WLK);
    if (s[4]) v |= bit_at(B_EOF);
    return v;
  endfunction
endpackage

// File: rtl/cas_bus_decode.sv
`timescale 1ns/1ps
module cas_bus_decode
  import cas_regif_pkg::*;
(
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic             bus_byte,
  input  logic [CSR_W-1:0] bus_wdata,
  input  logic [CSR_W-1:0] cs_q,
  input  logic             seq_busy,
  output logic             cs_wr_ev,
  output logic             db_rd_ev,
  output logic             db_wr_ev,
  output logic             db_odd_ev,
  output logic             go_ok_ev,
  output logic             go_busy_ev,
  output logic [CSR_W-1:0] merged
);
  logic db_wr_any;

  always_comb begin
    cs_wr_ev   = bus_sel && bus_we && !bus_addr[1];
    db_rd_ev   = bus_sel && !bus_we && bus_addr[1];
    db_wr_any  = bus_sel && bus_we && bus_addr[1];
    db_odd_ev  = db_wr_any && bus_byte && bus_addr[0];
    db_wr_ev   = db_wr_any && !db_odd_ev;
    merged     = merge_lanes(cs_q, bus_wdata, bus_byte, bus_addr[0]);
    go_ok_ev   = cs_wr_ev && merged[B_GO] && !seq_busy;
    go_busy_ev = cs_wr_ev && merged[B_GO] && seq_busy;
  end
endmodule

// File: rtl/cas_status_reg.sv
`timescale 1ns/1ps
module cas_status_reg
  import cas_regif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_wr_ev,
  input  logic                  db_rd_ev,
  input  logic                  db_wr_ev,
  input  logic                  go_ok_ev,
  input  logic [CSR_W-1:0]      merged,
  input  logic                  seq_tr_req,
  input  logic                  seq_done,
  input  logic [STAT_N-1:0]     seq_stat_set,
  input  logic [NUM_DRIVES-1:0] drv_loaded,
  output logic [CSR_W-1:0]      cs_q,
  output logic                  tim_ev
);
  logic [CSR_W-1:0] cs_d;
  logic             tr_set_ev;

  always_comb begin
    tim_ev    = seq_tr_req && cs_q[B_TR];
    tr_set_ev = seq_tr_req && !cs_q[B_TR];
    cs_d = cs_q | stat_bits(seq_stat_set);
    if (seq_done) cs_d[B_RDY] = 1'b1;
    if (tim_ev) begin
      cs_d[B_ERR] = 1'b1;
      cs_d[B_TIM] = 1'b1;
    end
    if (tr_set_ev) cs_d[B_TR] = 1'b1;
    if (cs_wr_ev) begin
      cs_d = apply_sw(cs_d, merged);
      if (go_ok_ev) cs_d = cs_d & ~start_clr_mask();
      if (cs_d[B_ILBS]) cs_d[B_TR] = 1'b0;
    end
    if (db_rd_ev || db_wr_ev) cs_d[B_TR] = 1'b0;
    if (!drv_loaded[cs_d[B_UNIT +: UNIT_W]]) begin
      cs_d[B_EMP] = 1'b1;
      cs_d[B_RDY] = 1'b1;
    end else begin
      cs_d[B_EMP] = 1'b0;
    end
    cs_d[B_GO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= bit_at(B_RDY);
    else        cs_q <= cs_d;
  end

  // R8
  tr_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tim_ev && !go_ok_ev |=> cs_q[B_ERR] && cs_q[B_TIM]);
  // R9
  ilbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr_ev && merged[B_ILBS] |=> !cs_q[B_TR]);
  // R7
  db_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_rd_ev |=> !cs_q[B_TR]);
  // R6
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok_ev |=> !cs_q[B_TR] && !cs_q[B_ERR] && !cs_q[B_TIM]);
  // R2
  go_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr_ev |=> !cs_q[B_GO]);
endmodule

// File: rtl/cas_data_bufs.sv
`timescale 1ns/1ps
module cas_data_bufs
  import cas_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_wr_ev,
  input  logic              db_odd_ev,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              seq_in_load,
  input  logic [BYTE_W-1:0] seq_in_byte,
  output logic [BYTE_W-1:0] in_byte_q,
  output logic [BYTE_W-1:0] out_byte_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_byte_q  <= '0;
      out_byte_q <= '0;
    end else begin
      if (seq_in_load) in_byte_q <= seq_in_byte;
      if (db_wr_ev) out_byte_q <= wr_byte;
    end
  end

  // R7
  odd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_odd_ev |=> $stable(out_byte_q));
endmodule

// File: rtl/cas_start_latch.sv
`timescale 1ns/1ps
module cas_start_latch
  import cas_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok_ev,
  input  logic              go_busy_ev,
  input  logic [CSR_W-1:0]  merged,
  output logic              start_pulse,
  output logic [UNIT_W-1:0] start_unit,
  output logic [FUNC_W-1:0] start_func
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      start_unit  <= '0;
      start_func  <= '0;
    end else begin
      start_pulse <= go_ok_ev;
      if (go_ok_ev) begin
        start_unit <= merged[B_UNIT +: UNIT_W];
        start_func <= merged[B_FUNC +: FUNC_W];
      end
    end
  end

  // R5
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy_ev |=> !start_pulse);
  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> $past(go_ok_ev));
endmodule

// File: rtl/cas_irq_gen.sv
`timescale 1ns/1ps
module cas_irq_gen
  import cas_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CSR_W-1:0] cs_q,
  output logic             irq
);
  assign irq = cs_q[B_IE] && (cs_q[B_TR] || cs_q[B_RDY]);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cs_q[B_IE]);
  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q[B_TR] && !cs_q[B_RDY] |-> !irq);
endmodule

// File: rtl/cas_regif_top.sv
`timescale 1ns/1ps
module cas_regif_top
  import cas_regif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_byte,
  input  logic [CSR_W-1:0]      bus_wdata,
  output logic [CSR_W-1:0]      bus_rdata,
  input  logic                  seq_busy,
  input  logic                  seq_tr_req,
  input  logic                  seq_done,
  input  logic [STAT_N-1:0]     seq_stat_set,
  input  logic                  seq_in_load,
  input  logic [BYTE_W-1:0]     seq_in_byte,
  input  logic [NUM_DRIVES-1:0] drv_loaded,
  output logic                  start_pulse,
  output logic [UNIT_W-1:0]     start_unit,
  output logic [FUNC_W-1:0]     start_func,
  output logic [BYTE_W-1:0]     out_byte,
  output logic                  irq
);
  logic             cs_wr_ev, db_rd_ev, db_wr_ev, db_odd_ev;
  logic             go_ok_ev, go_busy_ev, tim_ev;
  logic [CSR_W-1:0] merged, cs_q;
  logic [BYTE_W-1:0] in_byte_q;

  cas_bus_decode u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_byte(bus_byte), .bus_wdata(bus_wdata), .cs_q(cs_q),
    .seq_busy(seq_busy), .cs_wr_ev(cs_wr_ev), .db_rd_ev(db_rd_ev),
    .db_wr_ev(db_wr_ev), .db_odd_ev(db_odd_ev), .go_ok_ev(go_ok_ev),
    .go_busy_ev(go_busy_ev), .merged(merged)
  );

  cas_status_reg u_csr (
    .clk(clk), .rst_n(rst_n), .cs_wr_ev(cs_wr_ev), .db_rd_ev(db_rd_ev),
    .db_wr_ev(db_wr_ev), .go_ok_ev(go_ok_ev), .merged(merged),
    .seq_tr_req(seq_tr_req), .seq_done(seq_done),
    .seq_stat_set(seq_stat_set), .drv_loaded(drv_loaded),
    .cs_q(cs_q), .tim_ev(tim_ev)
  );

  cas_data_bufs u_bufs (
    .clk(clk), .rst_n(rst_n), .db_wr_ev(db_wr_ev), .db_odd_ev(db_odd_ev),
    .wr_byte(bus_wdata[BYTE_W-1:0]), .seq_in_load(seq_in_load),
    .seq_in_byte(seq_in_byte), .in_byte_q(in_byte_q), .out_byte_q(out_byte)
  );

  cas_start_latch u_start (
    .clk(clk), .rst_n(rst_n), .go_ok_ev(go_ok_ev), .go_busy_ev(go_busy_ev),
    .merged(merged), .start_pulse(start_pulse), .start_unit(start_unit),
    .start_func(start_func)
  );

  cas_irq_gen u_irq (.clk(clk), .rst_n(rst_n), .cs_q(cs_q), .irq(irq));

  assign bus_rdata = bus_addr[1] ? {{(CSR_W-BYTE_W){1'b0}}, in_byte_q} : cs_q;

  // R11
  empty_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[B_EMP] |-> cs_q[B_RDY]);
  // R4
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !cs_q[B_TR] && !cs_q[B_ERR]);
endmodule

// File: tb/cas_regif_tb.sv
`timescale 1ns/1ps
module cas_regif_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0, bus_byte = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        seq_busy = 0, seq_tr_req = 0, seq_done = 0, seq_in_load = 0;
  logic [4:0]  seq_stat_set = 0;
  logic [7:0]  seq_in_byte = 0;
  logic [1:0]  drv_loaded = 2'b11;
  logic        start_pulse, irq;
  logic [0:0]  start_unit;
  logic [2:0]  start_func;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cas_regif_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .seq_busy(seq_busy), .seq_tr_req(seq_tr_req),
    .seq_done(seq_done), .seq_stat_set(seq_stat_set),
    .seq_in_load(seq_in_load), .seq_in_byte(seq_in_byte),
    .drv_loaded(drv_loaded), .start_pulse(start_pulse),
    .start_unit(start_unit), .start_func(start_func),
    .out_byte(out_byte), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: integer arithmetic on the documented bit positions
  int m_cs, m_in, m_out, m_sp, m_su, m_sf;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 'h20; m_in = 0; m_out = 0; m_sp = 0; m_su = 0; m_sf = 0;
    end else begin
      int nx, w;
      nx = m_cs;
      for (int k = 0; k < 5; k++) if (seq_stat_set[k]) nx |= 1 << (15 - k);
      if (seq_done) nx |= 'h20;
      if (seq_tr_req) begin
        if (m_cs & 'h80) nx |= 'h8400; else nx |= 'h80;
      end
      m_sp = 0;
      if (bus_sel && bus_we && !bus_addr[1]) begin
        if (!bus_byte) w = bus_wdata;
        else if (bus_addr[0]) w = ((bus_wdata & 'hFF) << 8) | (m_cs & 'hFF);
        else w = (m_cs & 'hFF00) | (bus_wdata & 'hFF);
        nx = (nx & ~'h015E) | (w & 'h015E);
        if ((w & 1) && !seq_busy) begin
          nx &= ~'hFEA0;
          m_sp = 1; m_su = (w >> 8) & 1; m_sf = (w >> 1) & 7;
        end
        if (nx & 'h10) nx &= ~'h80;
      end
      if (bus_sel && !bus_we && bus_addr[1]) nx &= ~'h80;
      if (bus_sel && bus_we && bus_addr[1] && !(bus_byte && bus_addr[0])) begin
        m_out = bus_wdata & 'hFF;
        nx &= ~'h80;
      end
      if (seq_in_load) m_in = seq_in_byte;
      if (!drv_loaded[(nx >> 8) & 1]) nx |= 'h0220; else nx &= ~'h0200;
      m_cs = nx & 'hFFFF;
    end
  end

  always @(posedge clk) begin
    #2;
    begin
      int er, ei;
      er = bus_addr[1] ? m_in : m_cs;
      ei = ((m_cs >> 6) & 1) && (((m_cs >> 7) | (m_cs >> 5)) & 1);
      check(bus_rdata == er, "R2 model rdata", bus_rdata, er);
      check(irq == ei, "R10 model irq", irq, ei);
      check(out_byte == m_out, "R7 model out_byte", out_byte, m_out);
      check(start_pulse == m_sp, "R4 model start_pulse", start_pulse, m_sp);
      if (m_sp) begin
        check(start_unit == m_su, "R4 model start_unit", start_unit, m_su);
        check(start_func == m_sf, "R4 model start_func", start_func, m_sf);
      end
    end
  end

  task automatic bus_op(input bit we, input bit [1:0] a, input bit byt, input bit [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_byte = byt; bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic seq_op(input bit tr, input bit dn, input bit [4:0] st, input bit ld, input bit [7:0] b);
    @(negedge clk);
    seq_tr_req = tr; seq_done = dn; seq_stat_set = st; seq_in_load = ld; seq_in_byte = b;
    @(posedge clk); #2;
    seq_tr_req = 0; seq_done = 0; seq_stat_set = 0; seq_in_load = 0;
  endtask

  task automatic read_cs(output int v);
    bus_addr = 2'b00; #1; v = bus_rdata;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1; read_cs(v);
    check(v == 'h20, "R1 reset status", v, 'h20);
    check(irq == 0, "R1 reset irq", irq, 0);
    check(out_byte == 0, "R1 reset out_byte", out_byte, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #3; read_cs(v);
    check(v == 'h20, "R1 status after release", v, 'h20);

    seq_busy = 1;
    bus_op(1, 0, 0, 'hFFFF); read_cs(v);
    check(v == 'h017E, "R2 writable mask", v, 'h017E);
    check(start_pulse == 0, "R5 no start while busy", start_pulse, 0);
    check(irq == 1, "R10 irq on ready", irq, 1);
    bus_op(1, 1, 1, 'h0000); read_cs(v);
    check(v == 'h007E, "R3 odd byte keeps low", v, 'h007E);
    bus_op(1, 0, 0, 'h0100);
    bus_op(1, 0, 1, 'h000A); read_cs(v);
    check(v == 'h012A, "R3 even byte keeps high", v, 'h012A);

    seq_busy = 0;
    bus_op(1, 0, 0, 'h0105); read_cs(v);
    check(start_pulse == 1, "R4 start pulse", start_pulse, 1);
    check(start_unit == 1, "R4 start unit", start_unit, 1);
    check(start_func == 2, "R4 start func", start_func, 2);
    check(v == 'h0104, "R6 ready cleared by go", v, 'h0104);
    @(posedge clk); #3;
    check(start_pulse == 0, "R4 pulse one cycle", start_pulse, 0);

    seq_busy = 1;
    bus_op(1, 0, 0, 'h0105); read_cs(v);
    check(start_pulse == 0, "R5 go ignored while busy", start_pulse, 0);
    check(v == 'h0104, "R5 flags unchanged", v, 'h0104);

    seq_op(0, 0, 0, 1, 'h5A);
    seq_op(1, 0, 0, 0, 0); read_cs(v);
    check((v & 'h80) != 0, "R8 transfer request set", v, v | 'h80);
    bus_op(1, 0, 0, 'h0144);
    check(irq == 1, "R10 irq on transfer request", irq, 1);
    seq_op(1, 0, 0, 0, 0); read_cs(v);
    check((v & 'h8480) == 'h8480, "R8 timing error", v & 'h8480, 'h8480);
    bus_op(0, 2, 0, 0);
    check(bus_rdata == 'h5A, "R7 input byte read", bus_rdata, 'h5A);
    read_cs(v);
    check((v & 'h80) == 0, "R7 read clears request", v & 'h80, 0);
    check(irq == 0, "R10 irq dropped", irq, 0);
    check((v & 'h8400) == 'h8400, "R8 timing error kept", v & 'h8400, 'h8400);

    seq_op(1, 0, 0, 0, 0);
    bus_op(1, 3, 1, 'h0033); read_cs(v);
    check(out_byte == 0, "R7 odd data write ignored", out_byte, 0);
    check((v & 'h80) != 0, "R7 odd write keeps request", v & 'h80, 'h80);
    bus_op(1, 2, 1, 'h0033); read_cs(v);
    check(out_byte == 'h33, "R7 even data write", out_byte, 'h33);
    check((v & 'h80) == 0, "R7 data write clears request", v & 'h80, 0);

    seq_op(1, 0, 0, 0, 0);
    bus_op(1, 0, 0, 'h0154); read_cs(v);
    check((v & 'h80) == 0, "R9 start-CRC clears request", v & 'h80, 0);

    seq_op(0, 1, 5'b00110, 0, 0); read_cs(v);
    check((v & 'h6020) == 'h6020, "R12 sequencer flags", v & 'h6020, 'h6020);

    bus_op(1, 0, 0, 'h0104);
    @(negedge clk); drv_loaded = 2'b01;
    @(posedge clk); #3; read_cs(v);
    check((v & 'h0220) == 'h0220, "R11 empty forced", v & 'h0220, 'h0220);
    bus_op(1, 0, 0, 'h0004); read_cs(v);
    check((v & 'h0200) == 0, "R11 empty clears on loaded unit", v & 'h0200, 0);

    seq_busy = 0;
    bus_op(1, 0, 0, 'h0005); read_cs(v);
    check((v & 'hFEA0) == 0, "R6 go clears flags", v & 'hFEA0, 0);

    repeat (4) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule